// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block divides a fast input clock by an integer ratio whose high and low portions are set on their own. The high portion lasts `hi_len + 1` input cycles and the low portion `lo_len + 1` input cycles. The output period is therefore `hi_len + lo_len + 2` input cycles, anywhere from 2 to 32. A pass-through path supplies divide-by-1. Because the two portions are independent, a single ratio can be split in several ways. For example, a ratio of 5 can be set up as 1 high and 4 low, or as 3 high and 2 low.

A restart strobe is needed before the pattern runs. It also places the pattern in time. On the restart edge the block latches the new lengths. It then holds a chosen start level for a programmed delay of 0 to 15 input cycles, and after that it runs the chosen start portion. An optional correction stage handles odd ratios programmed with `lo_len = hi_len + 1`. It extends the high portion by half an input cycle, using a copy of the divided clock retimed on the falling input edge. This gives an exact 50% duty cycle.

Top module: `ckdiv_duty`

## Requirements
- R1: After reset, and until the first restart, `clk_out` is held low. Changes to the length, delay or start inputs do not alter it.
- R2: After a restart with `start_hi = 1`, the output has a period of `hi_len + lo_len + 2` input cycles. Within each period it is high for `hi_len + 1` cycles and low for `lo_len + 1` cycles. Each length field is 0 to 15, and the high portion comes first.
- R3: With `start_hi = 0` at the restart, the low portion of `lo_len + 1` cycles comes first.
- R4: The output holds the start level from the restart edge for `dly_len` extra input cycles before the first start portion begins. The start level is 1 if `start_hi` is 1, otherwise 0. As a result the first transition occurs `dly_len + (first portion length)` cycles after the restart edge.
- R5: Changes to `hi_len`, `lo_len`, `dly_len` and `start_hi` between restarts have no effect on the waveform until the next restart samples them.
- R6: When `dcc_dis = 0` and the latched lengths satisfy `lo_len = hi_len + 1`, each high portion is extended by half an input cycle. The output then goes low on a falling input edge, so it is high for `hi_len + 1.5` and low for `hi_len + 1.5` input cycles.
- R7: When `dcc_dis = 1`, or when the latched lengths do not satisfy `lo_len = hi_len + 1`, the uncorrected waveform is output. It changes only just after rising input edges.
- R8: While `pass_thru = 1`, `clk_out` follows `clk_in` (divide-by-1).
- R9: While `pass_thru = 1`, the divider state is frozen. On release, the pattern resumes from the point where it stopped, with no extra or missing cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Sampled on a rising edge: latch the settings and restart the pattern |
| hi_len | input | 4 | High portion length minus one |
| lo_len | input | 4 | Low portion length minus one |
| dly_len | input | 4 | Extra cycles the start level is held after a restart |
| start_hi | input | 1 | 1: start in the high portion; 0: start in the low portion |
| pass_thru | input | 1 | 1: route the input clock to the output and freeze the divider |
| dcc_dis | input | 1 | 1: disable the half-cycle duty correction |
| clk_out | output | 1 | Divided clock |

## Verification
A count register that is off by even one cycle shows up as a portion length error at the very next transition. The error then repeats on every later period, so the pattern is compared every half input cycle against an independent level-versus-cycle formula. A bad delay load shifts the first edge after a restart, and a wrong latched length shows up within one period. A correction stage that wrongly fires or fails to fire differs from the expected output at the first falling-edge sample of a high portion. Frozen state during pass-through is exposed by the first half cycle after release.

// File: rtl/ckdiv_pkg.sv
`timescale 1ns/1ps
package ckdiv_pkg;
   typedef enum logic {
      LVL_LOW  = 1'b0,
      LVL_HIGH = 1'b1
   } wave_lvl_e;
endpackage

// File: rtl/ckdiv_cfg_shadow.sv
`timescale 1ns/1ps
module ckdiv_cfg_shadow #(
   parameter int CNT_W = 4
) (
   input  logic             clk_in,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] hi_in,
   input  logic [CNT_W-1:0] lo_in,
   output logic [CNT_W-1:0] hi_q,
   output logic [CNT_W-1:0] lo_q,
   output logic             fit_q
);
   localparam logic [CNT_W:0] ONE_X = {{CNT_W{1'b0}}, 1'b1};

   logic fit_d;
   assign fit_d = ({1'b0, lo_in} == ({1'b0, hi_in} + ONE_X));

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         hi_q  <= '0;
         lo_q  <= '0;
         fit_q <= 1'b0;
      end else if (load) begin
         hi_q  <= hi_in;
         lo_q  <= lo_in;
         fit_q <= fit_d;
      end
   end

   AST_SHADOW_HOLD: assert property (@(posedge clk_in) disable iff (!rst_n)
      !load |=> ($stable(hi_q) && $stable(lo_q) && $stable(fit_q))); // R5
endmodule

// File: rtl/ckdiv_phase_delay.sv
`timescale 1ns/1ps
module ckdiv_phase_delay #(
   parameter int CNT_W = 4
) (
   input  logic             clk_in,
   input  logic             rst_n,
   input  logic             load,
   input  logic             hold,
   input  logic [CNT_W-1:0] dly_in,
   output logic             busy
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] dcnt;

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         dcnt <= '0;
      end else if (load) begin
         dcnt <= dly_in;
      end else if (!hold && (dcnt != '0)) begin
         dcnt <= dcnt - ONE;
      end
   end

   assign busy = (dcnt != '0);

   AST_DLY_LOADED: assert property (@(posedge clk_in) disable iff (!rst_n)
      load |=> (busy == ($past(dly_in) != '0))); // R4
endmodule

// File: rtl/ckdiv_pattern_gen.sv
`timescale 1ns/1ps
module ckdiv_pattern_gen
   import ckdiv_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk_in,
   input  logic             rst_n,
   input  logic             load,
   input  logic             hold,
   input  logic             busy,
   input  logic             start_in,
   input  logic [CNT_W-1:0] hi_in,
   input  logic [CNT_W-1:0] lo_in,
   input  logic [CNT_W-1:0] hi_q,
   input  logic [CNT_W-1:0] lo_q,
   output logic             wave,
   output logic             armed
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   wave_lvl_e        lvl;
   logic [CNT_W-1:0] pcnt;
   logic [CNT_W-1:0] longest;

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         lvl   <= LVL_LOW;
         pcnt  <= '0;
      end else if (load) begin
         armed <= 1'b1;
         lvl   <= start_in ? LVL_HIGH : LVL_LOW;
         pcnt  <= start_in ? hi_in : lo_in;
      end else if (armed && !hold && !busy) begin
         if (pcnt == '0) begin
            lvl  <= (lvl == LVL_HIGH) ? LVL_LOW : LVL_HIGH;
            pcnt <= (lvl == LVL_HIGH) ? lo_q : hi_q;
         end else begin
            pcnt <= pcnt - ONE;
         end
      end
   end

   assign wave    = (lvl == LVL_HIGH);
   assign longest = (hi_q > lo_q) ? hi_q : lo_q;

   AST_IDLE_UNARMED: assert property (@(posedge clk_in) disable iff (!rst_n)
      !armed |-> !wave); // R1
   AST_CNT_BOUND: assert property (@(posedge clk_in) disable iff (!rst_n)
      armed |-> (pcnt <= longest)); // R2
   AST_TOGGLE_AT_ZERO: assert property (@(posedge clk_in) disable iff (!rst_n)
      ((wave != $past(wave)) && !$past(load)) |-> ($past(pcnt) == '0)); // R2
   AST_HOLD_IN_DELAY: assert property (@(posedge clk_in) disable iff (!rst_n)
      (busy && !load) |=> $stable(wave)); // R4
   AST_BYPASS_FREEZE: assert property (@(posedge clk_in) disable iff (!rst_n)
      (hold && !load) |=> ($stable(pcnt) && $stable(wave))); // R9
endmodule

// File: rtl/ckdiv_duty.sv
`timescale 1ns/1ps
module ckdiv_duty #(
   parameter int CNT_W  = 4,
   parameter bit DCC_EN = 1'b1
) (
   input  logic             clk_in,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] hi_len,
   input  logic [CNT_W-1:0] lo_len,
   input  logic [CNT_W-1:0] dly_len,
   input  logic             start_hi,
   input  logic             pass_thru,
   input  logic             dcc_dis,
   output logic             clk_out
);
   if ((CNT_W < 2) || (CNT_W > 8)) begin : g_bad_width
      $error("ckdiv_duty: CNT_W must be within 2..8");
   end

   logic [CNT_W-1:0] hi_q;
   logic [CNT_W-1:0] lo_q;
   logic             fit_q;
   logic             busy;
   logic             wave;
   logic             armed;
   logic             wave_n;
   logic             dcc_act;
   logic             div_out;

   ckdiv_cfg_shadow #(.CNT_W(CNT_W)) u_shadow (
      .clk_in (clk_in),
      .rst_n  (rst_n),
      .load   (restart),
      .hi_in  (hi_len),
      .lo_in  (lo_len),
      .hi_q   (hi_q),
      .lo_q   (lo_q),
      .fit_q  (fit_q)
   );

   ckdiv_phase_delay #(.CNT_W(CNT_W)) u_delay (
      .clk_in (clk_in),
      .rst_n  (rst_n),
      .load   (restart),
      .hold   (pass_thru),
      .dly_in (dly_len),
      .busy   (busy)
   );

   ckdiv_pattern_gen #(.CNT_W(CNT_W)) u_pattern (
      .clk_in   (clk_in),
      .rst_n    (rst_n),
      .load     (restart),
      .hold     (pass_thru),
      .busy     (busy),
      .start_in (start_hi),
      .hi_in    (hi_len),
      .lo_in    (lo_len),
      .hi_q     (hi_q),
      .lo_q     (lo_q),
      .wave     (wave),
      .armed    (armed)
   );

   if (DCC_EN) begin : g_dcc
      logic wave_fall;
      always_ff @(negedge clk_in or negedge rst_n) begin
         if (!rst_n) begin
            wave_fall <= 1'b0;
         end else begin
            wave_fall <= wave;
         end
      end
      assign wave_n  = wave_fall;
      assign dcc_act = fit_q && !dcc_dis;
   end else begin : g_no_dcc
      assign wave_n  = wave;
      assign dcc_act = 1'b0;
   end

   assign div_out = dcc_act ? (wave | wave_n) : wave;
   assign clk_out = pass_thru ? clk_in : div_out;

   AST_OUT_LOW_UNARMED: assert property (@(posedge clk_in) disable iff (!rst_n)
      (!armed && !pass_thru) |-> !div_out); // R1
   AST_RAW_WHEN_NO_DCC: assert property (@(posedge clk_in) disable iff (!rst_n)
      !dcc_act |-> (div_out == wave)); // R7
endmodule

// File: tb/ckdiv_duty_test.sv
`timescale 1ns/1ps
module ckdiv_duty_test;
   logic       clk_in = 1'b0;
   logic       rst_n = 1'b0;
   logic       restart = 1'b0;
   logic [3:0] hi_len = '0;
   logic [3:0] lo_len = '0;
   logic [3:0] dly_len = '0;
   logic       start_hi = 1'b0;
   logic       pass_thru = 1'b0;
   logic       dcc_dis = 1'b1;
   logic       clk_out;

   int n_vec = 0;
   int n_bad = 0;

   // reference model state
   int   k = 0;
   int   mn = 0, mm = 0, mp = 0;
   logic ms = 1'b0;
   logic synced = 1'b0;
   logic lv_cur = 1'b0;
   logic lv_prev = 1'b0;
   string tag = "R1";

   always #2 clk_in = ~clk_in;

   ckdiv_duty uut (
      .clk_in    (clk_in),
      .rst_n     (rst_n),
      .restart   (restart),
      .hi_len    (hi_len),
      .lo_len    (lo_len),
      .dly_len   (dly_len),
      .start_hi  (start_hi),
      .pass_thru (pass_thru),
      .dcc_dis   (dcc_dis),
      .clk_out   (clk_out)
   );

   function automatic logic exp_level(int kk, int n, int m, int p, logic s);
      int a, b, t, u;
      a = s ? n + 1 : m + 1;
      b = s ? m + 1 : n + 1;
      t = kk - p;
      if (t < a) return s;
      u = (t - a) % (a + b);
      return (u < b) ? ~s : s;
   endfunction

   task automatic chk(string what, logic act, logic exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s k=%0d: got %b expected %b", tag, what, k, act, exp);
      end
   endtask

   // one input cycle: model update at the rising edge, samples in both halves
   task automatic cyc();
      logic dcc;
      @(posedge clk_in);
      lv_prev = lv_cur;
      if (restart) begin
         k = 0; mn = int'(hi_len); mm = int'(lo_len); mp = int'(dly_len);
         ms = start_hi; synced = 1'b1;
      end else if (!pass_thru && synced) begin
         k++;
      end
      lv_cur = synced ? exp_level(k, mn, mm, mp, ms) : 1'b0;
      dcc = !dcc_dis && (mm == mn + 1);
      #1;
      if (pass_thru) chk("bypass-hi", clk_out, 1'b1);
      else chk("rise-half", clk_out, dcc ? (lv_cur | lv_prev) : lv_cur);
      @(negedge clk_in);
      #1;
      if (pass_thru) chk("bypass-lo", clk_out, 1'b0);
      else chk("fall-half", clk_out, lv_cur);
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic do_restart(int n, int m, int p, logic s);
      hi_len = 4'(n); lo_len = 4'(m); dly_len = 4'(p); start_hi = s;
      restart = 1'b1;
      cyc();
      restart = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      int unsigned r;
      r = $urandom(32'd4711);
      // R1: reset state and idle before first restart
      tag = "R1";
      #9; rst_n = 1'b1;
      run(4);
      hi_len = 4'd3; lo_len = 4'd2; dly_len = 4'd1; start_hi = 1'b1;
      run(6);

      // R2: divide-by-5 as 1/4 and as 3/2, plus extremes
      tag = "R2"; dcc_dis = 1'b1;
      do_restart(0, 3, 0, 1'b1); run(25);
      do_restart(2, 1, 0, 1'b1); run(25);
      do_restart(0, 0, 0, 1'b1); run(10);
      do_restart(15, 15, 0, 1'b1); run(70);
      // R3: low portion first
      tag = "R3";
      do_restart(1, 4, 0, 1'b0); run(25);
      // R4: phase delay
      tag = "R4";
      do_restart(2, 2, 7, 1'b1); run(30);
      do_restart(0, 1, 15, 1'b0); run(30);
      // R5: settings changed without restart are ignored
      tag = "R5";
      do_restart(1, 2, 0, 1'b1); run(7);
      hi_len = 4'd9; lo_len = 4'd0; dly_len = 4'd5; start_hi = 1'b0;
      run(25);
      // R6: half-cycle correction when lo = hi + 1
      tag = "R6"; dcc_dis = 1'b0;
      do_restart(2, 3, 0, 1'b1); run(30);
      do_restart(0, 1, 3, 1'b0); run(20);
      // R7: no correction for a non-fitting split or when disabled
      tag = "R7";
      do_restart(3, 2, 0, 1'b1); run(20);
      dcc_dis = 1'b1;
      do_restart(2, 3, 0, 1'b1); run(20);
      // R8 / R9: pass-through and frozen state
      tag = "R8";
      do_restart(1, 3, 2, 1'b1); run(5);
      pass_thru = 1'b1; run(9);
      tag = "R9";
      pass_thru = 1'b0; run(20);
      dcc_dis = 1'b0;
      do_restart(4, 5, 0, 1'b1); run(3);
      pass_thru = 1'b1; run(4);
      pass_thru = 1'b0; run(20);

      // random mix
      for (int t = 0; t < 60; t++) begin
         tag = "R2";
         dcc_dis = 1'(($urandom() % 3) == 0);
         do_restart(int'($urandom() % 16), int'($urandom() % 16),
                    int'($urandom() % 16), 1'($urandom() % 2));
         run(int'(20 + $urandom() % 40));
         if (($urandom() % 4) == 0) begin
            tag = "R9";
            pass_thru = 1'b1; run(int'(1 + $urandom() % 6));
            pass_thru = 1'b0; run(20);
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule